// File: doc/BRIEF.md
# Service-Mode Programming Packet Sequencer

This block carries out one service-mode programming operation on the programming track. A host hands it a three-byte exec packet and a repeat count. The block then feeds a complete packet train to the track waveform generator. The train is a short run of all-zero reset packets, then the exec packet repeated, then a run of reset packets that fills out the train. No idle packet ever appears between these packets. While the train runs, the block watches the decoder acknowledge line and records whether an acknowledge was seen. When the last packet has been taken, it reports completion.

A single repeat count covers both writes and verifies. A verify uses 6 repeats, and the tail of reset packets lets the decoder recover. A write uses 12 repeats, and because the tail is shortened by the same amount, recovery for a write comes from the repeated write packet itself rather than from reset packets. How to read a CV bit by bit, and which addressing mode to use, is left to the host.

Top module: `svcp_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1 and `pkt_valid`, `done` and `ack_seen` are 0.
- R2: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. From the next cycle until the sequence ends, `req_ready` is 0 and `pkt_valid` is 1. A request raised during that time is not captured and does not change the packets sent.
- R3: Every sequence starts with exactly `NUM_PRE` (default 3) reset packets, each 24 bits of zero.
- R4: Straight after the leading reset packets, the captured exec packet is sent the requested number of times, with no other packet in between.
- R5: After the exec packets come `TAIL_LEN - n` reset packets, where `TAIL_LEN` defaults to 12 and n is the effective count. When n is at least `TAIL_LEN`, no reset packets follow. So a count of 6 gives 6 trailing resets, and counts of 12 or 15 give none.
- R6: A requested count of 0 is treated as 1.
- R7: When `pkt_valid` is 1 and `pkt_ready` is 0, `pkt_valid` stays 1 and `pkt_data` stays unchanged in the next cycle.
- R8: `ack_in` is asynchronous and passes through a two-stage synchronizer. `ack_seen` is set if the synchronized level is 1 in any cycle where the block is in the exec or trailing phase. An acknowledge that falls only within the leading reset phase is not counted.
- R9: `done` pulses for exactly one cycle, in the cycle after the handshake of the final packet. In that cycle `req_ready` is already 1. `ack_seen` keeps its value after `done` and is cleared in the cycle after the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Host requests a programming operation |
| req_ready | output | 1 | Block is idle and can take a request |
| req_pkt | input | PKT_W | Exec packet, three bytes |
| req_count | input | CNT_W | Number of times the exec packet is sent |
| pkt_valid | output | 1 | A programming-track packet is on offer |
| pkt_ready | input | 1 | Waveform generator takes the packet on offer |
| pkt_data | output | PKT_W | Packet on offer: zero for a reset packet, otherwise the exec packet |
| ack_in | input | 1 | Decoder acknowledge detected on the programming track, asynchronous |
| done | output | 1 | One-cycle pulse when the sequence is complete |
| ack_seen | output | 1 | An acknowledge was seen in the exec or trailing phase |

## Verification
The assertions place no limits on `pkt_ready`. The generator may stall for any number of cycles, so the hold rule on the packet output must hold under every back-pressure pattern. `req_valid` and `req_pkt` are assumed to matter only in cycles where `req_ready` is 1. `ack_in` is treated as fully asynchronous, so no property depends on when it rises. The stimulus drives every input half a cycle away from the capturing edge. It holds each acknowledge pulse for at least one full cycle and places it at a known packet index, so that the synchronizer delay decides which phase sees it. It raises busy-time requests only in the leading phase and drops them well before the final handshake.

// File: rtl/svcp_pkg.sv
package svcp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRE  = 2'd1,
    PH_EXEC = 2'd2,
    PH_POST = 2'd3
  } phase_t;
endpackage

// File: rtl/svcp_rst_sync.sv
module svcp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/svcp_ack_sync.sv
module svcp_ack_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ack_async_i,
  input  logic window_i,
  input  logic clear_i,
  output logic ack_seen_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   seen_q;
  logic                   seen_d;
  logic                   ack_lvl;

  assign ack_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    seen_d = seen_q;
    if (clear_i)                 seen_d = 1'b0;
    else if (window_i && ack_lvl) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      seen_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ack_async_i};
      seen_q <= seen_d;
    end
  end

  assign ack_seen_o = seen_q;

  AST_ACK_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    (seen_q && !clear_i) |=> seen_q);                      // R8
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    clear_i |=> !seen_q);                                  // R9
  AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    (!seen_q && !window_i) |=> !seen_q);                   // R8
endmodule

// File: rtl/svcp_seq_ctrl.sv
module svcp_seq_ctrl
  import svcp_pkg::*;
#(
  parameter int PKT_W    = 24,
  parameter int CNT_W    = 5,
  parameter int NUM_PRE  = 3,
  parameter int TAIL_LEN = 12
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PKT_W-1:0] start_pkt_i,
  input  logic [CNT_W-1:0] start_cnt_i,
  input  logic             pkt_ready_i,
  output phase_t           phase_o,
  output logic             pkt_valid_o,
  output logic [PKT_W-1:0] pkt_data_o,
  output logic             seq_end_o
);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(NUM_PRE - 1);
  localparam logic [CNT_W-1:0] TAIL_C   = CNT_W'(TAIL_LEN);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PKT_W-1:0] exec_q;
  logic [CNT_W-1:0] rep_q, post_q;
  logic [CNT_W-1:0] eff_cnt, post_calc;
  logic             hs;
  logic             seq_end;

  assign eff_cnt   = (start_cnt_i == '0) ? ONE : start_cnt_i;
  assign post_calc = (eff_cnt >= TAIL_C) ? '0 : (TAIL_C - eff_cnt);
  assign hs        = pkt_valid_o && pkt_ready_i;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    seq_end = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_PRE;
          cnt_d   = PRE_LAST;
        end
      end
      PH_PRE: begin
        if (hs) begin
          if (cnt_q == '0) begin
            phase_d = PH_EXEC;
            cnt_d   = rep_q - ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
      PH_EXEC: begin
        if (hs) begin
          if (cnt_q == '0) begin
            if (post_q == '0) begin
              phase_d = PH_IDLE;
              seq_end = 1'b1;
            end else begin
              phase_d = PH_POST;
              cnt_d   = post_q - ONE;
            end
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
      PH_POST: begin
        if (hs) begin
          if (cnt_q == '0) begin
            phase_d = PH_IDLE;
            seq_end = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      exec_q  <= '0;
      rep_q   <= '0;
      post_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (start_i && (phase_q == PH_IDLE)) begin
        exec_q <= start_pkt_i;
        rep_q  <= eff_cnt;
        post_q <= post_calc;
      end
    end
  end

  assign phase_o     = phase_q;
  assign pkt_valid_o = (phase_q != PH_IDLE);
  assign pkt_data_o  = (phase_q == PH_EXEC) ? exec_q : '0;
  assign seq_end_o   = seq_end;

  AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_data_o))); // R7
  AST_PRE_ORDER: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_q == PH_PRE) |=> (phase_q == PH_PRE || phase_q == PH_EXEC));     // R3
  AST_POST_ORDER: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_q == PH_POST) |=> (phase_q == PH_POST || phase_q == PH_IDLE));   // R5
  AST_NO_STALL_MOVE: assert property (@(posedge clk) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> $stable(phase_q));                    // R4
endmodule

// File: rtl/svcp_sequencer.sv
module svcp_sequencer
  import svcp_pkg::*;
#(
  parameter int PKT_W       = 24,
  parameter int CNT_W       = 5,
  parameter int NUM_PRE     = 3,
  parameter int TAIL_LEN    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PKT_W-1:0] req_pkt,
  input  logic [CNT_W-1:0] req_count,
  output logic             pkt_valid,
  input  logic             pkt_ready,
  output logic [PKT_W-1:0] pkt_data,
  input  logic             ack_in,
  output logic             done,
  output logic             ack_seen
);
  logic   rst_i_n;
  logic   start;
  logic   seq_end;
  logic   done_q;
  logic   window;
  phase_t phase;

  svcp_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_i_n)
  );

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign window    = (phase == PH_EXEC) || (phase == PH_POST);

  svcp_seq_ctrl #(
    .PKT_W    (PKT_W),
    .CNT_W    (CNT_W),
    .NUM_PRE  (NUM_PRE),
    .TAIL_LEN (TAIL_LEN)
  ) u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .start_i     (start),
    .start_pkt_i (req_pkt),
    .start_cnt_i (req_count),
    .pkt_ready_i (pkt_ready),
    .phase_o     (phase),
    .pkt_valid_o (pkt_valid),
    .pkt_data_o  (pkt_data),
    .seq_end_o   (seq_end)
  );

  svcp_ack_sync #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .ack_async_i (ack_in),
    .window_i    (window),
    .clear_i     (start),
    .ack_seen_o  (ack_seen)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) done_q <= 1'b0;
    else          done_q <= seq_end;
  end

  assign done = done_q;

  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    start |=> !req_ready);                                 // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_ready |-> !pkt_valid);                             // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);                                       // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> req_ready);                                   // R9
endmodule

// File: tb/sim_svcp_sequencer.sv
module sim_svcp_sequencer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_pkt;
  logic [4:0]  req_count;
  logic        pkt_valid;
  logic        pkt_ready;
  logic [23:0] pkt_data;
  logic        ack_in;
  logic        done;
  logic        ack_seen;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  svcp_sequencer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_pkt   (req_pkt),
    .req_count (req_count),
    .pkt_valid (pkt_valid),
    .pkt_ready (pkt_ready),
    .pkt_data  (pkt_data),
    .ack_in    (ack_in),
    .done      (done),
    .ack_seen  (ack_seen)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One complete operation: request, serve the packets, compare the train.
  task automatic run_op(input logic [23:0] pkt, input logic [4:0] cnt,
                        input int ack_k, input int ack_len, input bit stall,
                        input bit busy_try, input bit exp_ack, input string req);
    int  eff   = (cnt == 0) ? 1 : int'(cnt);
    int  post  = (eff >= 12) ? 0 : 12 - eff;
    int  tot   = 3 + eff + post;
    int  k     = 0;
    int  cyc   = 0;
    int  ack_left = 0;
    bit  fired = 0;
    bit  waiting = 0;
    bit  seq_ok = 1;
    bit  hold_ok = 1;
    bit  busy_ok = 1;
    bit  got_done = 0;
    int  bad_idx = -1;
    logic [23:0] held = '0;
    logic [23:0] expv;
    logic [23:0] bad_act = '0;
    logic [23:0] bad_exp = '0;

    @(negedge clk);
    chk(req_ready === 1'b1, "R2", "ready before request", req_ready, 1);
    req_valid = 1'b1;
    req_pkt   = pkt;
    req_count = cnt;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready === 1'b0, "R2", "ready after accept", req_ready, 0);
    chk(ack_seen === 1'b0, "R9", "ack_seen cleared on accept", ack_seen, 0);

    while (!got_done && cyc < 2000) begin
      if (done === 1'b1) begin
        got_done = 1'b1;
      end else begin
        if (ack_k >= 0 && !fired && k == ack_k) begin
          fired = 1'b1;
          ack_left = ack_len;
        end
        ack_in = (ack_left > 0);
        if (ack_left > 0) ack_left--;

        if (busy_try && k >= 1 && k < 3) begin
          req_valid = 1'b1;
          req_pkt   = 24'hFFFFFF;
          req_count = 5'd2;
          if (req_ready !== 1'b0) busy_ok = 1'b0;
        end else begin
          req_valid = 1'b0;
        end

        if (waiting && !(pkt_valid === 1'b1 && pkt_data === held)) hold_ok = 1'b0;

        if (pkt_valid === 1'b1) begin
          pkt_ready = !stall || (cyc % 3 == 2);
          if (pkt_ready) begin
            expv = (k >= 3 && k < 3 + eff) ? pkt : 24'h0;
            if (k >= tot || pkt_data !== expv) begin
              if (seq_ok) begin
                bad_idx = k; bad_act = pkt_data; bad_exp = expv;
              end
              seq_ok = 1'b0;
            end
            k++;
            waiting = 1'b0;
          end else begin
            waiting = 1'b1;
            held = pkt_data;
          end
        end else begin
          pkt_ready = 1'b0;
        end
        cyc++;
        @(negedge clk);
      end
    end

    req_valid = 1'b0;
    pkt_ready = 1'b0;
    ack_in    = 1'b0;
    chk(got_done, "R9", "done seen", got_done, 1);
    chk(seq_ok, "R3 R4 R5", $sformatf("packet %0d", bad_idx), bad_act, bad_exp);
    chk(k == tot, "R5", "packet count", k, tot);
    chk(ack_seen === exp_ack, "R8", "ack_seen at done", ack_seen, exp_ack);
    chk(req_ready === 1'b1, "R9", "ready with done", req_ready, 1);
    if (stall) chk(hold_ok, "R7", "offer held under stall", hold_ok, 1);
    if (busy_try) chk(busy_ok, "R2", "busy refuses request", busy_ok, 1);
    @(negedge clk);
    chk(done === 1'b0, "R9", "done single cycle", done, 0);
    chk(ack_seen === exp_ack, "R9", "ack_seen held", ack_seen, exp_ack);
    chk(pkt_valid === 1'b0, "R2", "no packet after end", pkt_valid, 0);
    $display("%s finished", req);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready === 1'b1, "R1", "req_ready", req_ready, 1);
    chk(pkt_valid === 1'b0, "R1", "pkt_valid", pkt_valid, 0);
    chk(done === 1'b0, "R1", "done", done, 0);
    chk(ack_seen === 1'b0, "R1", "ack_seen", ack_seen, 0);
  endtask

  // verify with an acknowledge during the exec packets
  task automatic t_verify_ack();
    run_op(24'h7C0A55, 5'd6, 5, 4, 1'b0, 1'b0, 1'b1, "R4_verify_ack");
  endtask

  // write with back-pressure: no trailing resets
  task automatic t_write_stall();
    run_op(24'h7C1233, 5'd12, -1, 0, 1'b1, 1'b0, 1'b0, "R7_write_stall");
  endtask

  // count of zero sends the exec packet once
  task automatic t_zero_count();
    run_op(24'h112233, 5'd0, -1, 0, 1'b0, 1'b0, 1'b0, "R6_zero_count");
  endtask

  // count beyond the tail length
  task automatic t_long_count();
    run_op(24'h0A0B0C, 5'd15, -1, 0, 1'b0, 1'b0, 1'b0, "R5_long_count");
  endtask

  // acknowledge only in the leading reset phase is ignored
  task automatic t_pre_ack();
    run_op(24'h7C0001, 5'd6, 0, 1, 1'b0, 1'b0, 1'b0, "R8_pre_ack");
  endtask

  // acknowledge late in the trailing resets, plus a refused busy request
  task automatic t_tail_ack_busy();
    run_op(24'h7D0203, 5'd6, 12, 3, 1'b0, 1'b1, 1'b1, "R2_tail_ack_busy");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_pkt   = '0;
    req_count = '0;
    pkt_ready = 1'b0;
    ack_in    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_verify_ack();
    t_write_stall();
    t_zero_count();
    t_long_count();
    t_pre_ack();
    t_tail_ack_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule